// File: doc/BRIEF.md
# Three-Leg Gate Blanking Conditioner

This block turns per-leg switching commands for a three-phase voltage source converter into upper and lower gate enables. Each leg has its own state machine. The machine makes sure both switches of a leg are off for a programmable number of clock cycles before either one turns on. It also ignores command excursions that are shorter than a programmable minimum width. Commands arrive in one of two modes. In complementary mode there is one PWM bit per leg. In independent mode there is a separate upper request and lower request per leg.

In independent mode a leg can receive an upper request and a lower request at the same time. When that happens, the leg turns both gates off at once, without waiting for the width filter, and raises a sticky per-leg fault flag. That flag stays set until a clear pulse arrives. The blanking count and the width count come from shared configuration inputs. A leg copies them only during reset or while it sits in its idle both-off state, so a leg that is switching keeps the timing it started with. All gate outputs and fault flags are flip-flops.

Top module: `vsc_gate_cond`

## Requirements
- R1: While `rst` is high, and after its release with no request applied, every gate output and every fault flag is 0.
- R2: `gate_top[i]` and `gate_bot[i]` are never 1 in the same cycle, for any input sequence.
- R3: Let Deff be the latched blanking count, with a value of 0 treated as 1. A change of side turns the outgoing gate off, and the incoming gate turns on exactly Deff edges later. A turn-on from the both-off state is also preceded by Deff edges with both gates off.
- R4: Let Weff be the latched minimum width, with a value of 0 treated as 1. A new request value is acted on only after it has been held for Weff consecutive sampling edges. If the first edge that samples it is counted as edge 1, the outgoing gate falls at edge Weff+1. A shorter excursion leaves the gates unchanged.
- R5: When `indep_mode`=0, `pwm_cmd[i]`=1 requests the upper switch of leg i and `pwm_cmd[i]`=0 requests the lower switch.
- R6: When `indep_mode`=1, the pair {`top_cmd[i]`,`bot_cmd[i]`} selects the leg's request: 10 requests the upper switch, 01 requests the lower switch, and 00 turns both gates off.
- R7: When `indep_mode`=1 and {`top_cmd[i]`,`bot_cmd[i]`}=11, both gates of leg i are 0 after the next edge, regardless of the width count, and `fault[i]` is 1.
- R8: `fault[i]` stays 1 until a cycle in which `fault_clr[i]`=1, and is 0 after that edge. If an illegal request and a clear arrive in the same cycle, the fault stays set.
- R9: If the request reverses while a leg is blanking, the leg stays with both gates off and starts a full new blanking count toward the newly requested side.
- R10: `dead_cfg` and `minw_cfg` are copied into a leg only during reset or while that leg is in its both-off state. A change made while the leg is active has no effect until the leg next passes through both-off.
- R11: The three legs are independent. Commands to one leg do not change the gates of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| indep_mode | input | 1 | 0: complementary PWM commands; 1: independent upper/lower requests |
| pwm_cmd | input | NLEG | Complementary command per leg (1 = upper switch) |
| top_cmd | input | NLEG | Independent upper-switch request per leg |
| bot_cmd | input | NLEG | Independent lower-switch request per leg |
| dead_cfg | input | CW | Blanking count in clock cycles |
| minw_cfg | input | CW | Minimum accepted command width in clock cycles |
| fault_clr | input | NLEG | Per-leg fault clear |
| gate_top | output | NLEG | Upper gate enable per leg |
| gate_bot | output | NLEG | Lower gate enable per leg |
| fault | output | NLEG | Sticky per-leg illegal-request flag |

## Verification
The assertions check every internal relation for any command sequence at all. The filter assertion only assumes that the raw request is a defined value on every edge after reset. The stimulus therefore drives every command and configuration bit to a known level from time zero. Timing checks that depend on the latched counts assume the configuration inputs were set while the leg was idle. For that reason the bench changes `dead_cfg` and `minw_cfg` only after returning the legs to both-off, except in the one case that deliberately tests late changes. In that case it waits long enough for the filter to settle before it measures any edge count.

// File: rtl/gc_pkg.sv
package gc_pkg;
  // Per-leg switching state
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_TOP    = 3'd1,
    ST_BOT    = 3'd2,
    ST_DT_TOP = 3'd3,
    ST_DT_BOT = 3'd4
  } leg_state_t;

  // Request encoding {upper, lower}
  localparam logic [1:0] REQ_NONE = 2'b00;
  localparam logic [1:0] REQ_TOP  = 2'b10;
  localparam logic [1:0] REQ_BOT  = 2'b01;
  localparam logic [1:0] REQ_BAD  = 2'b11;
endpackage

// File: rtl/gc_width_filter.sv
module gc_width_filter #(
  parameter int CW = 10,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] minw,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] filt
);
  localparam logic [CW-1:0] RUN_MAX = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [DW-1:0] cand_q, filt_q;
  logic [CW-1:0] run_q, run_nx, weff;
  logic          accept;

  always_comb begin
    weff = (minw == '0) ? ONE : minw;
    if (raw == cand_q)
      run_nx = (run_q == RUN_MAX) ? run_q : run_q + ONE;
    else
      run_nx = ONE;
    accept = (raw != filt_q) && (run_nx >= weff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      run_q  <= '0;
      filt_q <= '0;
    end else begin
      cand_q <= raw;
      run_q  <= run_nx;
      if (accept) filt_q <= raw;
    end
  end

  assign filt = filt_q;

  // R4: the filtered value only ever moves to the value just sampled
  a_r4_follow_raw: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> (filt_q == $past(raw)));
endmodule

// File: rtl/gc_dead_fsm.sv
module gc_dead_fsm
  import gc_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] dead_cfg,
  input  logic [CW-1:0] minw_cfg,
  input  logic [1:0]    req_raw,
  input  logic [1:0]    req_filt,
  input  logic          fault_clr,
  output logic [CW-1:0] minw_sh,
  output logic          gate_top,
  output logic          gate_bot,
  output logic          fault
);
  localparam logic [CW-1:0] ONE = CW'(1);

  leg_state_t    st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] dead_sh, minw_q;
  logic          illegal;

  assign illegal = (req_raw == REQ_BAD);

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    case (st_q)
      ST_OFF: begin
        if (req_filt == REQ_TOP) begin
          st_nx = ST_DT_TOP; cnt_nx = dead_sh;
        end else if (req_filt == REQ_BOT) begin
          st_nx = ST_DT_BOT; cnt_nx = dead_sh;
        end
      end
      ST_TOP: begin
        if (req_filt == REQ_BOT) begin
          st_nx = ST_DT_BOT; cnt_nx = dead_sh;
        end else if (req_filt != REQ_TOP) begin
          st_nx = ST_OFF;
        end
      end
      ST_BOT: begin
        if (req_filt == REQ_TOP) begin
          st_nx = ST_DT_TOP; cnt_nx = dead_sh;
        end else if (req_filt != REQ_BOT) begin
          st_nx = ST_OFF;
        end
      end
      ST_DT_TOP: begin
        if (req_filt == REQ_TOP) begin
          if (cnt_q <= ONE) st_nx = ST_TOP;
          else              cnt_nx = cnt_q - ONE;
        end else if (req_filt == REQ_BOT) begin
          st_nx = ST_DT_BOT; cnt_nx = dead_sh;
        end else begin
          st_nx = ST_OFF;
        end
      end
      ST_DT_BOT: begin
        if (req_filt == REQ_BOT) begin
          if (cnt_q <= ONE) st_nx = ST_BOT;
          else              cnt_nx = cnt_q - ONE;
        end else if (req_filt == REQ_TOP) begin
          st_nx = ST_DT_TOP; cnt_nx = dead_sh;
        end else begin
          st_nx = ST_OFF;
        end
      end
      default: st_nx = ST_OFF;
    endcase
    if (illegal) st_nx = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      cnt_q    <= '0;
      gate_top <= 1'b0;
      gate_bot <= 1'b0;
      fault    <= 1'b0;
      dead_sh  <= dead_cfg;
      minw_q   <= minw_cfg;
    end else begin
      st_q     <= st_nx;
      cnt_q    <= cnt_nx;
      gate_top <= (st_nx == ST_TOP);
      gate_bot <= (st_nx == ST_BOT);
      if (illegal)        fault <= 1'b1;
      else if (fault_clr) fault <= 1'b0;
      if (st_q == ST_OFF) begin
        dead_sh <= dead_cfg;
        minw_q  <= minw_cfg;
      end
    end
  end

  assign minw_sh = minw_q;

  // R2: no cross conduction
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_top && gate_bot));
  // R3: a turn-on never follows the opposite gate directly
  a_r3_blank_top: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_top) |-> $past(!gate_bot));
  a_r3_blank_bot: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_bot) |-> $past(!gate_top));
  // R7: illegal pair blocks both gates and flags
  a_r7_illegal_off: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (!gate_top && !gate_bot && fault));
  // R8: flag holds without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault && !fault_clr) |=> fault);
  // R10: timing copies frozen while the leg is active
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_OFF) |=> ($stable(dead_sh) && $stable(minw_q)));
endmodule

// File: rtl/gc_leg.sv
module gc_leg #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    req_raw,
  input  logic [CW-1:0] dead_cfg,
  input  logic [CW-1:0] minw_cfg,
  input  logic          fault_clr,
  output logic          gate_top,
  output logic          gate_bot,
  output logic          fault
);
  logic [1:0]    req_filt;
  logic [CW-1:0] minw_sh;

  gc_width_filter #(.CW(CW), .DW(2)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .minw (minw_sh),
    .raw  (req_raw),
    .filt (req_filt)
  );

  gc_dead_fsm #(.CW(CW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .dead_cfg (dead_cfg),
    .minw_cfg (minw_cfg),
    .req_raw  (req_raw),
    .req_filt (req_filt),
    .fault_clr(fault_clr),
    .minw_sh  (minw_sh),
    .gate_top (gate_top),
    .gate_bot (gate_bot),
    .fault    (fault)
  );
endmodule

// File: rtl/vsc_gate_cond.sv
module vsc_gate_cond #(
  parameter int NLEG = 3,
  parameter int CW   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            indep_mode,
  input  logic [NLEG-1:0] pwm_cmd,
  input  logic [NLEG-1:0] top_cmd,
  input  logic [NLEG-1:0] bot_cmd,
  input  logic [CW-1:0]   dead_cfg,
  input  logic [CW-1:0]   minw_cfg,
  input  logic [NLEG-1:0] fault_clr,
  output logic [NLEG-1:0] gate_top,
  output logic [NLEG-1:0] gate_bot,
  output logic [NLEG-1:0] fault
);
  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic [1:0] req;
    // R5 / R6: mode selects how the leg request is formed
    assign req = indep_mode ? {top_cmd[g], bot_cmd[g]}
                            : {pwm_cmd[g], ~pwm_cmd[g]};

    gc_leg #(.CW(CW)) u_leg (
      .clk      (clk),
      .rst      (rst),
      .req_raw  (req),
      .dead_cfg (dead_cfg),
      .minw_cfg (minw_cfg),
      .fault_clr(fault_clr[g]),
      .gate_top (gate_top[g]),
      .gate_bot (gate_bot[g]),
      .fault    (fault[g])
    );
  end
endmodule

// File: tb/tb_vsc_gate_cond.sv
module tb_vsc_gate_cond;
  localparam int NLEG = 3;
  localparam int CW   = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic            indep_mode;
  logic [NLEG-1:0] pwm_cmd, top_cmd, bot_cmd, fault_clr;
  logic [CW-1:0]   dead_cfg, minw_cfg;
  logic [NLEG-1:0] gate_top, gate_bot, fault;

  int n_chk = 0;
  int n_bad = 0;
  int n_overlap = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vsc_gate_cond #(.NLEG(NLEG), .CW(CW)) dut (
    .clk(clk), .rst(rst), .indep_mode(indep_mode), .pwm_cmd(pwm_cmd),
    .top_cmd(top_cmd), .bot_cmd(bot_cmd), .dead_cfg(dead_cfg),
    .minw_cfg(minw_cfg), .fault_clr(fault_clr), .gate_top(gate_top),
    .gate_bot(gate_bot), .fault(fault)
  );

  // {dead count, minimum width}
  localparam logic [19:0] VEC [0:5] = '{
    {10'd1, 10'd1}, {10'd0, 10'd0}, {10'd3, 10'd2},
    {10'd5, 10'd1}, {10'd2, 10'd4}, {10'd6, 10'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go_idle(input int d, input int w);
    indep_mode = 1'b1;
    top_cmd = '0;
    bot_cmd = '0;
    dead_cfg = CW'(d);
    minw_cfg = CW'(w);
    wait_edges(40);
  endtask

  // R2 monitor away from the edge
  always @(negedge clk)
    if (!rst && ((gate_top & gate_bot) != '0)) n_overlap++;

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; indep_mode = 1'b1; pwm_cmd = '1; top_cmd = '0; bot_cmd = '0;
    dead_cfg = 10'd2; minw_cfg = 10'd1; fault_clr = '0;
    wait_edges(4);
    check("R1 gate_top in reset", gate_top, 0);
    check("R1 gate_bot in reset", gate_bot, 0);
    check("R1 fault in reset", fault, 0);
    rst = 1'b0;
    wait_edges(5);
    check("R1 gates after release", {gate_top, gate_bot, fault}, 0);

    // Table walk: turn-on from idle, then side change on leg 0
    for (int v = 0; v < 6; v++) begin
      int d, w, de, we;
      d = int'(VEC[v][19:10]);
      w = int'(VEC[v][9:0]);
      de = (d == 0) ? 1 : d;
      we = (w == 0) ? 1 : w;
      go_idle(d, w);
      check("R6 idle both off", {gate_top, gate_bot}, 0);
      pwm_cmd = 3'b001;
      indep_mode = 1'b0;
      wait_edges(we + de);
      check("R3 top still blanked", gate_top, 0);
      wait_edges(1);
      check("R5 leg0 top on", gate_top, 3'b001);
      check("R5 legs1-2 bottom on", gate_bot, 3'b110);
      pwm_cmd = 3'b000;
      wait_edges(we);
      check("R4 top held until width met", gate_top[0], 1);
      wait_edges(1);
      check("R3 outgoing top off", gate_top, 0);
      check("R11 other legs unchanged", gate_bot, 3'b110);
      wait_edges(de - 1);
      check("R3 bottom still blanked", gate_bot[0], 0);
      wait_edges(1);
      check("R3 bottom on after dead count", gate_bot, 3'b111);
    end

    // R4: narrow notch rejected, exact-width notch accepted
    go_idle(2, 4);
    pwm_cmd = 3'b111; indep_mode = 1'b0;
    wait_edges(30);
    check("R4 setup all top", gate_top, 3'b111);
    pwm_cmd = 3'b110;
    wait_edges(3);
    check("R4 short notch during", gate_top, 3'b111);
    pwm_cmd = 3'b111;
    wait_edges(10);
    check("R4 short notch top kept", gate_top, 3'b111);
    check("R4 short notch bottom never", gate_bot, 3'b000);
    pwm_cmd = 3'b110;
    wait_edges(4);
    check("R4 width notch before accept", gate_top[0], 1);
    pwm_cmd = 3'b111;
    wait_edges(1);
    check("R4 width notch accepted", gate_top[0], 0);
    wait_edges(20);
    check("R4 recovery to top", gate_top, 3'b111);

    // R9: reversal during blanking restarts full count
    go_idle(5, 1);
    pwm_cmd = 3'b111; indep_mode = 1'b0;
    wait_edges(20);
    pwm_cmd = 3'b110;
    wait_edges(2);
    check("R9 both off at reversal", {gate_top[0], gate_bot[0]}, 0);
    pwm_cmd = 3'b111;
    wait_edges(6);
    check("R9 still blanked", {gate_top[0], gate_bot[0]}, 0);
    wait_edges(1);
    check("R9 top after new full count", {gate_top[0], gate_bot[0]}, 2'b10);

    // R10: late change of dead count ignored until idle
    go_idle(2, 1);
    pwm_cmd = 3'b111; indep_mode = 1'b0;
    wait_edges(20);
    dead_cfg = 10'd9;
    wait_edges(5);
    pwm_cmd = 3'b110;
    wait_edges(3);
    check("R10 old count blanking", gate_bot[0], 0);
    wait_edges(1);
    check("R10 old count used", gate_bot[0], 1);
    go_idle(9, 1);
    pwm_cmd = 3'b111; indep_mode = 1'b0;
    wait_edges(10);
    check("R10 new count blanking", gate_top[0], 0);
    wait_edges(1);
    check("R10 new count used", gate_top[0], 1);

    // R7 / R8: illegal pair in independent mode
    go_idle(3, 4);
    bot_cmd = 3'b111;
    wait_edges(30);
    check("R6 bottoms on", gate_bot, 3'b111);
    top_cmd = 3'b001;
    wait_edges(1);
    check("R7 illegal gates off", {gate_top, gate_bot}, {3'b000, 3'b110});
    check("R7 fault raised", fault, 3'b001);
    wait_edges(5);
    top_cmd = '0; bot_cmd = '0;
    wait_edges(20);
    check("R8 fault sticky", fault, 3'b001);
    fault_clr = 3'b001;
    wait_edges(1);
    fault_clr = '0;
    check("R8 fault cleared", fault, 3'b000);
    top_cmd = 3'b010; bot_cmd = 3'b010; fault_clr = 3'b010;
    wait_edges(1);
    check("R8 set wins over clear", fault, 3'b010);
    top_cmd = '0; bot_cmd = '0; fault_clr = '0;
    wait_edges(20);
    top_cmd = 3'b100;
    wait_edges(7);
    check("R6 top blanked", gate_top, 0);
    wait_edges(1);
    check("R6 independent top on", gate_top, 3'b100);
    check("R2 no overlap seen", n_overlap, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule